// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This core is the sampled-phase oscillator inside a digital clock-synthesis loop. On every sample clock it adds a frequency tuning word to a 48-bit phase accumulator that wraps modulo 2^48 and keeps the remainder. It adds a 14-bit phase offset to the truncated phase. It then turns the resulting angle into a signed 14-bit amplitude sample for a downstream DAC. The output frequency is `word * f_sample / 2^48`. For example, a 1 GHz sample clock needs the word 0x04FA05143BF7 to produce 19.44 MHz.

The tuning word comes from one of three sources. In closed-loop operation it is the word most recently accepted from the loop filter. In holdover the core keeps running on that accepted word while ignoring the loop. In single-tone operation it uses a register word with its least significant bit forced to zero, and it ignores every loop-side input. The angle-to-amplitude converter folds a quarter-wave table, which is computed at elaboration, over the four quadrants. The accumulator value is also exported so that a neighbouring phase detector can use it.

Top module: `nco_core`

## Requirements
- R1: On every clock out of reset the accumulator becomes its previous value plus the selected tuning word, modulo 2^48, so the excess is retained on rollover.
- R2: Mode is sampled from the inputs on each clock and acts one clock later: `loop_closed_i`=1 is closed loop (word = last accepted loop word); otherwise `single_tone_i`=1 is single tone (word = `reg_ftw_i`); otherwise holdover (word = last accepted loop word).
- R3: In single-tone mode bit 0 of the tuning word is taken as zero, so an odd register word steps the accumulator by one less.
- R4: A loop word is accepted only on a clock where `loop_valid_i` is high while the registered mode is closed loop. In holdover and single tone, `loop_ftw_i` and `loop_valid_i` have no effect on the step.
- R5: `sample_o` equals round(8191 * sin(2*pi*k/1024)) within 1 LSB, in two's complement. k is bits [18:9] of the 19-bit phase `acc[47:29] + (phase_ofs_i << 5)` mod 2^19. k = 0, 256, 512 and 768 give exactly 0, +8191, 0 and -8191, and -8192 never appears.
- R6: The sample seen after clock edge n is computed from the accumulator value produced by edge n-3. The fixed latency is three clocks.
- R7: An offset of 16*m shifts the phase index by m. With a word of 2^38 this advances the output by m samples.
- R8: A clock edge with `rst_n` low clears the accumulator, the accepted loop word and the output pipeline to zero, and selects single-tone mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_ftw_i | input | 48 | Register tuning word for single tone |
| loop_ftw_i | input | 48 | Tuning word from the loop filter |
| loop_valid_i | input | 1 | Qualifies `loop_ftw_i` |
| phase_ofs_i | input | 14 | Phase offset, 2*pi/2^14 rad per LSB |
| loop_closed_i | input | 1 | 1 = closed loop, 0 = open loop |
| single_tone_i | input | 1 | Open-loop choice: 1 = single tone, 0 = holdover |
| acc_o | output | 48 | Phase accumulator value |
| sample_o | output | 14 | Signed amplitude sample |

## Verification
The assertions watch four things on every clock: the accumulator advances by the selected word with wraparound, the accumulator LSB never changes in single-tone mode, the word stays frozen during continuous holdover, and the sample never reaches the unbalanced negative code. They also confirm the state right after reset. Only the bench scenarios can show that each mode picks the right source and ignores the loop inputs when it should. The same holds for the actual sine values at the quadrant points, the three-clock alignment between accumulator and sample, and the sample shift produced by the offset.

// File: rtl/nco_pkg.sv
// nco_pkg: shared mode type and the quarter-wave table generator.
// Assumes the table generator is only called with constant arguments.
package nco_pkg;

    typedef enum logic [1:0] {
        MODE_TONE   = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_CLOSED = 2'd2
    } nco_mode_t;

    // pi/2 in Q30 fixed point
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // Amplitude of sin(idx/steps * pi/2) scaled to amp, Taylor series in Q30.
    function automatic int quarter_sine(input int idx, input int steps, input int amp);
        longint x;
        longint term;
        longint sum;
        longint res;
        x    = (longint'(idx) * HALF_PI_Q30) / longint'(steps);
        term = x;
        sum  = x;
        for (int k = 1; k <= 7; k++) begin
            term = (((term * x) >>> 30) * x) >>> 30;
            term = -(term / longint'((2 * k) * (2 * k + 1)));
            sum  = sum + term;
        end
        res = (sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
        if (res > longint'(amp)) res = longint'(amp);
        if (res < 0) res = 0;
        return int'(res);
    endfunction

endpackage

// File: rtl/nco_tune_sel.sv
// nco_tune_sel: registers the operating mode, holds the accepted loop word
// and selects the tuning word for the accumulator.
// Assumes: mode inputs are synchronous to clk; reset is synchronous active-low.
module nco_tune_sel
    import nco_pkg::*;
#(
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] reg_ftw_i,
    input  logic [ACC_W-1:0] loop_ftw_i,
    input  logic             loop_valid_i,
    input  logic             loop_closed_i,
    input  logic             single_tone_i,
    output nco_mode_t        mode_o,
    output logic [ACC_W-1:0] ftw_o
);

    nco_mode_t        mode_q;
    nco_mode_t        mode_d;
    logic [ACC_W-1:0] hold_q;

    // Decode the requested mode: closed loop wins over the open-loop choice.
    always_comb begin
        if (loop_closed_i)      mode_d = MODE_CLOSED;
        else if (single_tone_i) mode_d = MODE_TONE;
        else                    mode_d = MODE_HOLD;
    end

    // Register the mode and capture loop words only while closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_TONE;
            hold_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (mode_q == MODE_CLOSED && loop_valid_i) begin
                hold_q <= loop_ftw_i;
            end
        end
    end

    // Select the word: register word with LSB cleared, else the held loop word.
    always_comb begin
        if (mode_q == MODE_TONE) ftw_o = reg_ftw_i & ~ACC_W'(1);
        else                     ftw_o = hold_q;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/nco_phase_path.sv
// nco_phase_path: phase accumulator plus offset injection and truncation.
// Assumes OFS_W <= PHASE_W <= ACC_W and IDX_W <= PHASE_W; offset is MSB-aligned.
module nco_phase_path #(
    parameter int ACC_W   = 48,
    parameter int PHASE_W = 19,
    parameter int OFS_W   = 14,
    parameter int IDX_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int ALIGN_W = PHASE_W - OFS_W;
    localparam int DROP_W  = PHASE_W - IDX_W;

    logic [ACC_W-1:0]   acc_q;
    logic [PHASE_W-1:0] ofs_aligned;
    logic [IDX_W-1:0]   idx_q;

    assign ofs_aligned = {ofs_i, {ALIGN_W{1'b0}}};

    // Accumulate the tuning word, wrapping naturally at 2^ACC_W.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + ftw_i;
    end

    // Add the offset to the top phase bits and keep the table index bits.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= IDX_W'((acc_q[ACC_W-1 -: PHASE_W] + ofs_aligned) >> DROP_W);
    end

    assign acc_o = acc_q;
    assign idx_o = idx_q;

endmodule

// File: rtl/nco_sine_conv.sv
// nco_sine_conv: angle-to-amplitude conversion by quarter-wave folding.
// Assumes: top two index bits are the quadrant; table holds 2^LUT_AW+1 points
// covering 0..pi/2 inclusive; two register stages.
module nco_sine_conv
    import nco_pkg::*;
#(
    parameter int LUT_AW = 8,
    parameter int AMP_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LUT_AW+1:0]       idx_i,
    output logic signed [AMP_W-1:0] sample_o
);

    localparam int N       = 2 ** LUT_AW;
    localparam int MAG_W   = AMP_W - 1;
    localparam int AMP_MAX = 2 ** MAG_W - 1;

    logic [MAG_W-1:0]  rom [0:N];
    logic [1:0]        quad;
    logic [LUT_AW-1:0] addr;
    logic [LUT_AW:0]   fold;
    logic [MAG_W-1:0]  mag_q;
    logic              neg_q;
    logic [AMP_W-1:0]  mag_ext;
    logic [AMP_W-1:0]  sample_q;

    // Quarter-wave table, one constant entry per point.
    for (genvar i = 0; i <= N; i++) begin : g_rom
        assign rom[i] = MAG_W'(quarter_sine(i, N, AMP_MAX));
    end

    assign quad = idx_i[LUT_AW+1 -: 2];
    assign addr = idx_i[LUT_AW-1:0];

    // Mirror the address in the second and fourth quadrants.
    always_comb begin
        if (quad[0]) fold = (LUT_AW + 1)'(N) - {1'b0, addr};
        else         fold = {1'b0, addr};
    end

    // Stage one: table lookup and sign of the half-wave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mag_q <= rom[fold];
            neg_q <= quad[1];
        end
    end

    assign mag_ext = {1'b0, mag_q};

    // Stage two: apply the sign in two's complement.
    always_ff @(posedge clk) begin
        if (!rst_n)     sample_q <= '0;
        else if (neg_q) sample_q <= -mag_ext;
        else            sample_q <= mag_ext;
    end

    assign sample_o = $signed(sample_q);

endmodule

// File: rtl/nco_core.sv
// nco_core: numerically controlled oscillator with selectable tuning source.
// Assumes one sample per clock, synchronous active-low reset, and that the
// offset is applied in the phase stage (three clocks from accumulator to sample).
module nco_core
    import nco_pkg::*;
#(
    parameter int ACC_W   = 48,
    parameter int PHASE_W = 19,
    parameter int OFS_W   = 14,
    parameter int AMP_W   = 14,
    parameter int LUT_AW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        reg_ftw_i,
    input  logic [ACC_W-1:0]        loop_ftw_i,
    input  logic                    loop_valid_i,
    input  logic [OFS_W-1:0]        phase_ofs_i,
    input  logic                    loop_closed_i,
    input  logic                    single_tone_i,
    output logic [ACC_W-1:0]        acc_o,
    output logic signed [AMP_W-1:0] sample_o
);

    localparam int IDX_W = LUT_AW + 2;

    nco_mode_t        mode_q;
    logic [ACC_W-1:0] ftw_sel;
    logic [IDX_W-1:0] idx;

    nco_tune_sel #(.ACC_W(ACC_W)) u_tune (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_ftw_i     (reg_ftw_i),
        .loop_ftw_i    (loop_ftw_i),
        .loop_valid_i  (loop_valid_i),
        .loop_closed_i (loop_closed_i),
        .single_tone_i (single_tone_i),
        .mode_o        (mode_q),
        .ftw_o         (ftw_sel)
    );

    nco_phase_path #(
        .ACC_W   (ACC_W),
        .PHASE_W (PHASE_W),
        .OFS_W   (OFS_W),
        .IDX_W   (IDX_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ftw_i (ftw_sel),
        .ofs_i (phase_ofs_i),
        .acc_o (acc_o),
        .idx_o (idx)
    );

    nco_sine_conv #(
        .LUT_AW (LUT_AW),
        .AMP_W  (AMP_W)
    ) u_sine (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_i    (idx),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/nco_core_checker.sv
// nco_core_checker: concurrent properties for nco_core, attached by bind.
// Assumes the default widths of 48-bit accumulator and 14-bit samples.
module nco_core_checker
    import nco_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int AMP_W = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input nco_mode_t               mode_q,
    input logic [ACC_W-1:0]        ftw_sel,
    input logic [ACC_W-1:0]        acc_o,
    input logic signed [AMP_W-1:0] sample_o
);

    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    // R1: accumulator advances by the previously selected word, wrapping.
    p_step_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> acc_o == $past(acc_o) + $past(ftw_sel));

    // R3: single-tone steps are even, so the accumulator LSB holds.
    p_tone_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_q) == MODE_TONE) |-> acc_o[0] == $past(acc_o[0]));

    // R4: in continuous holdover the selected word does not move.
    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == MODE_HOLD && $past(mode_q) == MODE_HOLD)
        |-> ftw_sel == $past(ftw_sel));

    // R5: the unbalanced most-negative code never appears.
    p_no_min_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != $signed(MOST_NEG));

    // R8: the first cycle after reset shows cleared state and single tone.
    p_reset_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (acc_o == '0 && sample_o == '0 && mode_q == MODE_TONE));

endmodule

bind nco_core nco_core_checker #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .ftw_sel  (ftw_sel),
    .acc_o    (acc_o),
    .sample_o (sample_o)
);

// File: tb/nco_core_bench.sv
// nco_core_bench: vector walk over tuning modes, then directed tests.
module nco_core_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [47:0]        reg_ftw = '0;
    logic [47:0]        loop_ftw = '0;
    logic               loop_valid = 1'b0;
    logic [13:0]        ofs = '0;
    logic               closed = 1'b0;
    logic               tone = 1'b1;
    logic [47:0]        acc;
    logic signed [13:0] sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [47:0] a0 = '0, a1 = '0, a2 = '0, a3 = '0;

    always #5 clk = ~clk;

    nco_core u_nco_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_ftw_i     (reg_ftw),
        .loop_ftw_i    (loop_ftw),
        .loop_valid_i  (loop_valid),
        .phase_ofs_i   (ofs),
        .loop_closed_i (closed),
        .single_tone_i (tone),
        .acc_o         (acc),
        .sample_o      (sample)
    );

    typedef struct packed {
        logic        closed;
        logic        tone;
        logic [47:0] reg_w;
        logic [47:0] loop_w;
        logic        valid;
        logic [47:0] step;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 48'd5,    48'd0,     1'b0, 48'd4,    4'd3}, // R3 odd word drops LSB
        '{1'b0, 1'b1, 48'd6,    48'd0,     1'b0, 48'd6,    4'd2}, // R2 single tone
        '{1'b1, 1'b0, 48'd0,    48'd5,     1'b1, 48'd5,    4'd2}, // R2 closed loop, odd kept
        '{1'b1, 1'b0, 48'd0,    48'd7,     1'b0, 48'd5,    4'd4}, // R4 no strobe, no capture
        '{1'b0, 1'b0, 48'd0,    48'd9,     1'b1, 48'd5,    4'd4}, // R4 holdover ignores loop
        '{1'b0, 1'b1, 48'd1000, 48'd9,     1'b1, 48'd1000, 4'd4}, // R4 tone ignores loop
        '{1'b1, 1'b0, 48'd0,    48'd9,     1'b1, 48'd9,    4'd2}, // R2 closed takes new word
        '{1'b0, 1'b0, 48'd0,    48'h123,   1'b1, 48'd9,    4'd2}  // R2 holdover keeps word
    };

    task automatic check48(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%012h expected 0x%012h", req, act, exp);
        end
    endtask

    function automatic int model_sample(input logic [47:0] a, input logic [13:0] o);
        logic [18:0] p;
        real r;
        p = a[47:29] + {o, 5'b0};
        r = 8191.0 * $sin(2.0 * 3.14159265358979 * real'(int'(p[18:9])) / 1024.0);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    // One clock; shift accumulator history; optionally check the sample (R5, R6).
    task automatic tick(input bit chk);
        int exp;
        int act;
        int d;
        logic [18:0] p;
        @(negedge clk);
        a3 = a2; a2 = a1; a1 = a0; a0 = acc;
        if (chk) begin
            exp = model_sample(a3, ofs);
            act = int'(sample);
            d = act - exp;
            p = a3[47:29] + {ofs, 5'b0};
            checks++;
            if (p[8:0] == 9'd0 && (p[18:9] == 10'd0 || p[18:9] == 10'd256 ||
                                   p[18:9] == 10'd512 || p[18:9] == 10'd768)) begin
                if (act != exp) begin
                    fails++;
                    $display("FAIL R5 quadrant point: actual %0d expected %0d", act, exp);
                end
            end else if (d > 1 || d < -1) begin
                fails++;
                $display("FAIL R6/R5 sample: actual %0d expected %0d", act, exp);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        a0 = '0; a1 = '0; a2 = '0; a3 = '0;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] prev;
        int cnt;
        // R8: reset state, with closed loop requested during reset
        closed = 1'b1; tone = 1'b0; reg_ftw = 48'd10; loop_ftw = 48'd77; loop_valid = 1'b0;
        repeat (3) @(negedge clk);
        check48("R8 acc in reset", acc, 48'd0);
        check48("R8 sample in reset", 48'(sample), 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check48("R8 single tone after reset", acc, 48'd10);

        // Vector walk over modes (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            closed = VEC[i].closed; tone = VEC[i].tone; reg_ftw = VEC[i].reg_w;
            loop_valid = 1'b0;
            @(negedge clk);
            loop_ftw = VEC[i].loop_w; loop_valid = VEC[i].valid;
            repeat (4) @(negedge clk);
            prev = acc;
            @(negedge clk);
            checks++;
            if (acc - prev !== VEC[i].step) begin
                fails++;
                $display("FAIL R%0d vector %0d step: actual %0d expected %0d",
                         VEC[i].req, i, acc - prev, VEC[i].step);
            end
        end
        loop_valid = 1'b0;

        // R1: wrap keeping the excess
        closed = 1'b0; tone = 1'b1; reg_ftw = 48'hFFFF_FFFF_FFFA;
        do_reset();
        @(negedge clk);
        check48("R1 first step", acc, 48'hFFFF_FFFF_FFFA);
        @(negedge clk);
        check48("R1 wrap remainder", acc, 48'hFFFF_FFFF_FFF4);

        // R5, R6: one table index per clock, offset zero
        reg_ftw = 48'h40_0000_0000; ofs = '0;
        do_reset();
        for (int n = 0; n < 1100; n++) tick(n >= 4);

        // R7: offset of 64 advances by four samples
        ofs = 14'd64;
        for (int n = 0; n < 4; n++) tick(1'b0);
        cnt = 0;
        for (int n = 0; n < 1100; n++) begin
            tick(1'b1);
            if (a3[47:38] == 10'd252) begin
                cnt++;
                checks++;
                if (int'(sample) != 8191) begin
                    fails++;
                    $display("FAIL R7 shifted peak: actual %0d expected 8191", int'(sample));
                end
            end
        end
        checks++;
        if (cnt == 0) begin
            fails++;
            $display("FAIL R7 peak index seen: actual 0 expected >0");
        end

        // R5: a realistic tuning word
        ofs = 14'd1000; reg_ftw = 48'h04FA_0514_3BF7;
        do_reset();
        for (int n = 0; n < 600; n++) tick(n >= 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule